// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is an SPI master that exchanges 8-bit frames under the control of a small 32-bit register port. Software chooses the clock mode and the bit rate, sets the chip-select level by hand, and writes a byte to the transmit register. That write starts one full-duplex exchange. During the exchange the byte leaves on the data-out line, most significant bit first, and the byte arriving on the data-in line is collected. At the end the received byte is held in the receive register and a status flag is raised.

The serial clock comes from the system clock through a divider with two stages. A coarse stage divides by 16 or by 128. A fine stage then divides by 2×(n+1), where n is a 5-bit field. Each half period of the serial clock therefore lasts coarse×(n+1) system clocks. Chip select is not driven by the transfer logic. It follows a level bit that software writes, and it is only asserted when the master-enable bit is set.

Registers are decoded by byte address. Reads are combinational. A read is qualified by a read strobe, because reading the receive register has a side effect.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every register reads zero, cs_n is 1 and sclk is 0.
- R2: Register map. Control is at 0x00 and reads back its 8 bits. Status is at 0x04. System control is at 0x08 and reads back its 8 bits. The transmit register is at 0x0C and the receive register is at 0x10. Offsets 0x0C and 0x14 read as zero.
- R3: Each sclk half period lasts (control bit 5 ? 128 : 16) × (control[4:0] + 1) clock cycles. The first sclk edge comes one half period after the transmit write.
- R4: While no exchange is running, sclk rests at the level of control bit 6 (CPOL).
- R5: With control bit 7 (CPHA) at 0, the first data bit is on mosi before the first sclk edge. Both lines are sampled on the leading edges and change on the trailing edges. Data moves most significant bit first in both directions.
- R6: With CPHA at 1, mosi changes on leading edges and both lines are sampled on trailing edges. Data moves most significant bit first in both directions.
- R7: Status bit 0 is 1 from the transmit write until the sixteenth sclk edge. At that edge status bit 2 is set and the receive register holds the byte shifted in from miso.
- R8: A read of the receive register clears status bit 2. A write to status with bit 2 at 0 also clears it.
- R9: A transmit write is ignored while status bit 0 is 1, and also while system-control bit 0 (master enable) is 0.
- R10: cs_n is 0 only when system-control bit 0 is 1 and bit 6 is 0. Writing 0x21 asserts it and writing 0x61 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for the receive-register side effect) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, software-set level |

## Verification
The hardest case to reach is a second transmit write that arrives in the middle of a running exchange. It must leave the byte being shifted untouched and must not start another frame. The bench issues that write partway through a transfer, at a point chosen by counting sclk edges. It then checks three things: the frame seen by a slave model on mosi, the data returned in the receive register, and the fact that no further sclk edges appear afterwards. Both clock phases are also run against a slave model that changes miso on the opposite edge, which makes any off-by-one-edge error in sampling show up.

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int FRAME  = 8,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int NW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);
  localparam int CW    = $clog2(PRE_HI * (2 ** NW)) + 1;
  localparam int EDGES = 2 * FRAME;
  localparam int EW    = $clog2(EDGES);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_SYS  = AW'(8'h08);
  localparam logic [AW-1:0] A_TX   = AW'(8'h0C);
  localparam logic [AW-1:0] A_RX   = AW'(8'h10);

  logic [7:0]       ctrl_q, sys_q;
  logic [FRAME-1:0] sh_q, rxbuf_q;
  logic             busy_q, rxf_q, rxbit_q, sclk_q;
  logic [EW-1:0]    edge_q;
  logic [CW-1:0]    cnt_q, half;
  logic             start, tick, cpha, sample_edge, last_edge, hold_first;
  logic             unused_ok;

  assign half        = (ctrl_q[5] ? CW'(PRE_HI) : CW'(PRE_LO)) * (CW'(ctrl_q[NW-1:0]) + 1'b1);
  assign tick        = busy_q && (cnt_q == half - 1'b1);
  assign start       = wr_en && addr == A_TX && sys_q[0] && !busy_q;
  assign cpha        = ctrl_q[7];
  assign sample_edge = cpha ? edge_q[0] : !edge_q[0];
  assign last_edge   = edge_q == EW'(EDGES - 1);
  assign hold_first  = cpha && edge_q == '0;
  assign unused_ok   = ^wdata[DW-1:8];

  assign sclk = busy_q ? sclk_q : ctrl_q[6];
  assign mosi = sh_q[FRAME-1];
  assign cs_n = ~(sys_q[0] & ~sys_q[6]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sys_q   <= '0;
      sh_q    <= '0;
      rxbuf_q <= '0;
      busy_q  <= 1'b0;
      rxf_q   <= 1'b0;
      rxbit_q <= 1'b0;
      sclk_q  <= 1'b0;
      edge_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata[7:0];
      if (wr_en && addr == A_SYS)  sys_q  <= wdata[7:0];
      if (wr_en && addr == A_STAT && !wdata[2]) rxf_q <= 1'b0;
      if (rd_en && addr == A_RX) rxf_q <= 1'b0;

      if (start) begin
        sh_q   <= wdata[FRAME-1:0];
        busy_q <= 1'b1;
        edge_q <= '0;
        cnt_q  <= '0;
        sclk_q <= ctrl_q[6];
      end else if (tick) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (sample_edge) rxbit_q <= miso;
        else if (!hold_first) sh_q <= {sh_q[FRAME-2:0], rxbit_q};
        if (last_edge) begin
          busy_q  <= 1'b0;
          rxf_q   <= 1'b1;
          rxbuf_q <= cpha ? {sh_q[FRAME-2:0], miso} : {sh_q[FRAME-2:0], rxbit_q};
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[7:0] = ctrl_q;
      A_STAT:  begin rdata[2] = rxf_q; rdata[0] = busy_q; end
      A_SYS:   rdata[7:0] = sys_q;
      A_RX:    rdata[FRAME-1:0] = rxbuf_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic          busy,
  input logic          rxf,
  input logic          en,
  input logic          cpol,
  input logic          sclk,
  input logic          cs_n
);
  localparam logic [AW-1:0] A_TX = AW'(8'h0C);
  localparam logic [AW-1:0] A_RX = AW'(8'h10);

  a_r7_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rxf);

  a_r9_start_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == A_TX && en));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RX && !busy) |=> !rxf);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sclk));

  a_r10_cs_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> en);
endmodule

bind spi_regmaster spi_regmaster_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .busy(busy_q), .rxf(rxf_q), .en(sys_q[0]), .cpol(ctrl_q[6]),
  .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, miso, cs_n;

  int total = 0, bad = 0;
  int cyc = 0;
  int ec = 0;
  int t0 = 0, t1 = 0;
  logic [7:0] sbyte = '0, cap = '0;
  logic b_cpha = 1'b0, b_cpol = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_regmaster dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  function automatic int bit_idx(int e, logic ph);
    int i;
    i = ph ? ((e == 0) ? 0 : (e - 1) >> 1) : (e >> 1);
    if (i > 7) i = 7;
    return i;
  endfunction
  assign miso = sbyte[7 - bit_idx(ec, b_cpha)];

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(sclk) begin
    if (ec < 16) begin
      if (((sclk != b_cpol) ? 1'b1 : 1'b0) ^ b_cpha) cap = {cap[6:0], mosi};
      if (ec == 0) t0 = cyc;
      if (ec == 1) t1 = cyc;
      ec = ec + 1;
      if (ec == 16) begin
        if (exp_q.size() == 0) check("R9 unexpected frame", 1, 0);
        else check(b_cpha ? "R6 mosi frame" : "R5 mosi frame", int'(cap), exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    while (s[0]) rd(5'h04, s);
  endtask

  task automatic xfer(logic [7:0] ctrl, logic [7:0] tx, logic [7:0] sl, int half);
    logic [31:0] d;
    wr(5'h00, {24'h0, ctrl});
    b_cpha = ctrl[7]; b_cpol = ctrl[6];
    sbyte = sl; ec = 0;
    exp_q.push_back(int'(tx));
    wr(5'h0C, {24'h0, tx});
    wait_idle();
    check("R3 half period", t1 - t0, half);
    rd(5'h04, d); check("R7 rx flag set", int'(d[2]), 1);
    rd(5'h10, d); check(ctrl[7] ? "R6 rx byte" : "R5 rx byte", int'(d[7:0]), int'(sl));
    rd(5'h04, d); check("R8 flag cleared by read", int'(d[2]), 0);
    #1 check("R4 idle level", int'(sclk), int'(ctrl[6]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 check("R1 cs_n reset", int'(cs_n), 1);
    check("R1 sclk reset", int'(sclk), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(5'h00, d); check("R1 ctrl reset", int'(d), 0);
    rd(5'h04, d); check("R1 status reset", int'(d), 0);
    rd(5'h08, d); check("R1 sysctl reset", int'(d), 0);
    rd(5'h10, d); check("R1 rx reset", int'(d), 0);

    wr(5'h0C, 32'hA5);
    rd(5'h04, d); check("R9 disabled write ignored", int'(d[0]), 0);

    wr(5'h08, 32'h21);
    #1 check("R10 cs asserted", int'(cs_n), 0);
    rd(5'h08, d); check("R2 sysctl readback", int'(d), 32'h21);
    wr(5'h00, 32'hDF);
    rd(5'h00, d); check("R2 ctrl readback", int'(d), 32'hDF);
    rd(5'h14, d); check("R2 offset 0x14 zero", int'(d), 0);
    rd(5'h0C, d); check("R2 tx reads zero", int'(d), 0);

    xfer(8'h00, 8'hA5, 8'h3C, 16);
    xfer(8'h40, 8'h81, 8'hE7, 16);
    xfer(8'h82, 8'h5A, 8'hC3, 48);
    xfer(8'hC0, 8'h0F, 8'h96, 16);
    xfer(8'h20, 8'h71, 8'h1E, 128);

    wr(5'h00, 32'h00); b_cpha = 1'b0; b_cpol = 1'b0;
    sbyte = 8'h69; ec = 0; exp_q.push_back(32'hC6);
    wr(5'h0C, 32'hC6);
    while (ec < 5) @(negedge clk);
    rd(5'h04, d); check("R7 busy during exchange", int'(d[0]), 1);
    wr(5'h0C, 32'hFF);
    wait_idle();
    rd(5'h10, d); check("R9 rx after ignored write", int'(d[7:0]), 32'h69);
    repeat (100) @(negedge clk);
    check("R9 no extra edges", ec, 16);
    rd(5'h04, d); check("R9 not busy after ignored write", int'(d[0]), 0);
    check("R7 flag after ignored write", int'(d[2]), 0);

    sbyte = 8'h11; ec = 0; exp_q.push_back(32'h22);
    wr(5'h0C, 32'h22);
    wait_idle();
    rd(5'h04, d); check("R7 flag before status write", int'(d[2]), 1);
    wr(5'h04, 32'h0);
    rd(5'h04, d); check("R8 flag cleared by status write", int'(d[2]), 0);
    rd(5'h10, d); check("R7 rx byte kept", int'(d[7:0]), 32'h11);

    wr(5'h08, 32'h61);
    #1 check("R10 cs released", int'(cs_n), 1);
    check("R3 queue empty", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule